// File: doc/BRIEF.md
# Selective Fence Ordering Gate

This block sits between the decode stage and the memory issue path of a core whose fences carry two 4-bit class masks, a predecessor set and a successor set, over four access classes: device input, device output, memory read and memory write. It keeps a running count of outstanding operations per class. When a fence is accepted, it records a snapshot of the outstanding counts for the predecessor classes. From then on it holds back only the successor classes, and only until those recorded earlier operations have drained. Newer operations that are still in flight do not extend the hold.

Atomic operations reuse the same mechanism. A release atomic is issued only once no memory read or write is outstanding. An acquire atomic, once granted, installs an implicit fence whose predecessor set is read and write, with the atomic itself included in the snapshot, and whose successor set is read and write. At most two fences, explicit or implicit, are pending at once. A third fence stalls decode until a slot frees.

Top module: `fence_gate`

## Requirements
- R1: After reset, all per-class counts are zero and no fence is pending. `fence_ready` is 1 and a request of any class is granted.
- R2: `req_cls` encodes W=0, R=1, O=2, I=3, and bit k of `cmp_valid` reports one completion of class k. A granted request increments its class count and a completion decrements it. Completions within a class return in issue order, and at most 15 operations per class are outstanding.
- R3: Mask bits are I=bit3, O=bit2, R=bit1, W=bit0. A fence whose predecessor or successor mask is zero is accepted and has no effect on any grant.
- R4: A fence with predecessor 0011 and successor 0011 holds every read and write request until all reads and writes issued at or before the fence have completed.
- R5: A fence with predecessor 0010 and successor 0010 holds reads only, and only behind earlier reads. Writes pass.
- R6: A fence with predecessor 0001 and successor 0001 holds writes only, and only behind earlier writes. Reads pass.
- R7: A fence with predecessor 0010 and successor 0011 holds both reads and writes behind earlier reads only.
- R8: A fence with predecessor 0011 and successor 0001 holds writes behind earlier reads and writes. Reads pass.
- R9: A request granted in the same cycle that a fence is accepted counts as earlier than the fence. Requests granted later do not delay its release. The held classes are released in the cycle after the last recorded predecessor completion is signalled.
- R10: A granted request with `req_aq` set holds all later read and write requests until the atomic and every read and write issued before it have completed.
- R11: A request with `req_rl` set is granted only when no read or write is outstanding. With both `req_aq` and `req_rl` set, both rules apply.
- R12: At most two fences are pending. `fence_ready` is 0 while two are pending. An acquire request is granted only when a slot is free beyond the one needed by a fence accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fence_valid | input | 1 | Fence presented by decode |
| fence_pred | input | 4 | Predecessor class mask |
| fence_succ | input | 4 | Successor class mask |
| fence_ready | output | 1 | Fence accepted this cycle when valid; low stalls decode |
| req_valid | input | 1 | Operation requests issue |
| req_cls | input | 2 | Class of the requested operation |
| req_aq | input | 1 | Acquire ordering on an atomic |
| req_rl | input | 1 | Release ordering on an atomic |
| req_grant | output | 1 | Operation may issue this cycle |
| cmp_valid | input | 4 | Per-class completion strobes |

## Verification
On every cycle, the assertions check that a class count rises only on a grant of that class and falls only on a completion of that class. They also check that no pending snapshot ever exceeds the live count of its class, and that a release atomic is never granted while memory operations are outstanding. Only the bench scenarios can show that the correct classes are held for each mask pair, that release happens in the right cycle, that newer traffic does not prolong a fence, and how the two-slot limit stalls fences and acquire atomics. The bench does this by comparing grant and ready against a queue-based model on every cycle.

// File: rtl/fence_gate.sv
module fence_gate #(
  parameter int CW    = 4,
  parameter int SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fence_valid,
  input  logic [3:0] fence_pred,
  input  logic [3:0] fence_succ,
  output logic       fence_ready,
  input  logic       req_valid,
  input  logic [1:0] req_cls,
  input  logic       req_aq,
  input  logic       req_rl,
  output logic       req_grant,
  input  logic [3:0] cmp_valid
);
  localparam int NW = $clog2(SLOTS + 1);

  logic [CW-1:0] cnt [4];
  logic [CW-1:0] cnt_n [4];
  logic [SLOTS-1:0] vld, vld_n;
  logic [3:0] succ_q [SLOTS];
  logic [3:0] succ_n [SLOTS];
  logic [CW-1:0] rem_q [SLOTS][4];
  logic [CW-1:0] rem_n [SLOTS][4];

  logic [3:0] blocked;
  logic [NW-1:0] nfree;
  logic fence_live, fence_acc, f_need, mem_busy;
  logic [CW-1:0] fsnap [4];
  logic f_alloc, a_alloc;

  always_comb begin
    blocked = '0;
    nfree   = '0;
    for (int e = 0; e < SLOTS; e++) begin
      if (vld[e]) blocked = blocked | succ_q[e];
      else        nfree   = nfree + 1'b1;
    end
  end

  assign fence_live  = (fence_pred != 4'd0) && (fence_succ != 4'd0);
  assign fence_ready = (nfree != '0);
  assign fence_acc   = fence_valid && fence_ready;
  assign f_need      = fence_acc && fence_live;
  assign mem_busy    = (cnt[0] != '0) || (cnt[1] != '0);

  assign req_grant = req_valid && !blocked[req_cls]
                   && !(req_rl && mem_busy)
                   && !(req_aq && (nfree <= NW'(f_need)));

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      cnt_n[k] = cnt[k] + CW'(req_grant && (req_cls == k)) - CW'(cmp_valid[k]);
      fsnap[k] = fence_pred[k] ? cnt_n[k] : '0;
    end
  end

  assign f_alloc = f_need && ((fsnap[0] | fsnap[1] | fsnap[2] | fsnap[3]) != '0);
  assign a_alloc = req_grant && req_aq && ((cnt_n[0] | cnt_n[1]) != '0);

  always_comb begin
    logic fa, aa, live;
    fa = f_alloc;
    aa = a_alloc;
    for (int e = 0; e < SLOTS; e++) begin
      live = 1'b0;
      succ_n[e] = succ_q[e];
      for (int k = 0; k < 4; k++) begin
        rem_n[e][k] = rem_q[e][k] - CW'(cmp_valid[k] && (rem_q[e][k] != '0));
        if (rem_n[e][k] != '0) live = 1'b1;
      end
      vld_n[e] = vld[e] && live;
      if (!vld_n[e] && fa) begin
        fa = 1'b0;
        vld_n[e] = 1'b1;
        succ_n[e] = fence_succ;
        for (int k = 0; k < 4; k++) rem_n[e][k] = fsnap[k];
      end else if (!vld_n[e] && aa) begin
        aa = 1'b0;
        vld_n[e] = 1'b1;
        succ_n[e] = 4'b0011;
        rem_n[e][0] = cnt_n[0];
        rem_n[e][1] = cnt_n[1];
        rem_n[e][2] = '0;
        rem_n[e][3] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int k = 0; k < 4; k++) cnt[k] <= '0;
      for (int e = 0; e < SLOTS; e++) begin
        succ_q[e] <= '0;
        for (int k = 0; k < 4; k++) rem_q[e][k] <= '0;
      end
    end else begin
      vld <= vld_n;
      for (int k = 0; k < 4; k++) cnt[k] <= cnt_n[k];
      for (int e = 0; e < SLOTS; e++) begin
        succ_q[e] <= succ_n[e];
        for (int k = 0; k < 4; k++) rem_q[e][k] <= rem_n[e][k];
      end
    end
  end

  genvar gk, ge;
  generate
    for (gk = 0; gk < 4; gk++) begin : g_cls
      // R2
      cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[gk] > $past(cnt[gk])) |-> ($past(req_grant) && ($past(req_cls) == gk)));
      // R2
      cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[gk] < $past(cnt[gk])) |-> $past(cmp_valid[gk]));
      for (ge = 0; ge < SLOTS; ge++) begin : g_slot
        // R9
        snap_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
          vld[ge] |-> (rem_q[ge][gk] <= cnt[gk]));
      end
    end
  endgenerate

  // R11
  rl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant && req_rl) |-> (cnt[0] == '0 && cnt[1] == '0));
endmodule

// File: tb/sim_fence_gate.sv
module sim_fence_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fence_valid = 1'b0;
  logic [3:0] fence_pred = '0, fence_succ = '0;
  logic fence_ready;
  logic req_valid = 1'b0;
  logic [1:0] req_cls = '0;
  logic req_aq = 1'b0, req_rl = 1'b0;
  logic req_grant;
  logic [3:0] cmp_valid = '0;

  int vectors = 0, fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  typedef struct packed {
    logic [3:0] succ;
    logic [3:0][7:0] rem;
  } ent_t;
  ent_t q[$];
  int mcnt[4];

  always #10 clk = ~clk;

  fence_gate u0 (.*);

  function automatic bit m_ready();
    return q.size() < 2;
  endfunction

  function automatic bit m_grant();
    logic [3:0] blk = '0;
    int need;
    foreach (q[i]) blk |= q[i].succ;
    need = (fence_valid && m_ready() && fence_pred != 0 && fence_succ != 0) ? 1 : 0;
    if (!req_valid) return 1'b0;
    if (blk[req_cls]) return 1'b0;
    if (req_rl && (mcnt[0] != 0 || mcnt[1] != 0)) return 1'b0;
    if (req_aq && (2 - q.size()) <= need) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int k = 0; k < 4; k++) mcnt[k] = 0;
    end else begin
      bit g, facc;
      int cn[4];
      ent_t ne;
      g = m_grant();
      facc = fence_valid && m_ready();
      for (int k = 0; k < 4; k++)
        cn[k] = mcnt[k] + ((g && req_cls == k) ? 1 : 0) - (cmp_valid[k] ? 1 : 0);
      foreach (q[i])
        for (int k = 0; k < 4; k++)
          if (cmp_valid[k] && q[i].rem[k] != 0) q[i].rem[k] = q[i].rem[k] - 1;
      for (int i = q.size() - 1; i >= 0; i--)
        if (q[i].rem == '0) q.delete(i);
      if (facc && fence_pred != 0 && fence_succ != 0) begin
        ne = '0;
        ne.succ = fence_succ;
        for (int k = 0; k < 4; k++) if (fence_pred[k]) ne.rem[k] = 8'(cn[k]);
        if (ne.rem != '0) q.push_back(ne);
      end
      if (g && req_aq) begin
        ne = '0;
        ne.succ = 4'b0011;
        ne.rem[0] = 8'(cn[0]);
        ne.rem[1] = 8'(cn[1]);
        if (ne.rem != '0) q.push_back(ne);
      end
      for (int k = 0; k < 4; k++) mcnt[k] = cn[k];
    end
  end

  task automatic check(input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input int fpct, input logic [3:0] fp, input logic [3:0] fs,
                      input int cpct, input int atom);
    int c;
    @(negedge clk);
    c = $urandom_range(3);
    req_cls   = 2'(c);
    req_valid = ($urandom_range(99) < 55) && (mcnt[c] < 12);
    req_aq    = (atom & 1) ? $urandom_range(1) : 1'b0;
    req_rl    = (atom & 2) ? $urandom_range(1) : 1'b0;
    fence_valid = ($urandom_range(99) < fpct);
    fence_pred  = fp;
    fence_succ  = fs;
    for (int k = 0; k < 4; k++)
      cmp_valid[k] = (mcnt[k] > 0) && ($urandom_range(99) < cpct);
    #5;
    check(req_grant, m_grant(), "req_grant");
    check(fence_ready, m_ready(), "fence_ready");
  endtask

  task automatic phase(input string t, input logic [3:0] fp, input logic [3:0] fs,
                       input int fpct, input int cpct, input int atom, input int n);
    tag = t;
    for (int i = 0; i < n; i++) step(fpct, fp, fs, cpct, atom);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle state grants every class
    tag = "R1";
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      req_valid = 1'b0;
      #5;
      check(fence_ready, 1'b1, "fence_ready after reset");
      req_valid = 1'b1;
      req_cls = 2'(c);
      #1;
      check(req_grant, 1'b1, "grant after reset");
      req_valid = 1'b0;
      @(posedge clk);
    end
    // R5: directed read-after-read hold, write passes
    tag = "R5";
    @(negedge clk); req_valid = 1'b1; req_cls = 2'd1;
    @(negedge clk); req_valid = 1'b0; fence_valid = 1'b1; fence_pred = 4'b0010; fence_succ = 4'b0010;
    @(negedge clk); fence_valid = 1'b0; req_valid = 1'b1; req_cls = 2'd1; #5;
    check(req_grant, 1'b0, "read held behind earlier read");
    req_cls = 2'd0; #1;
    check(req_grant, 1'b1, "write passes read fence");
    req_valid = 1'b0;
    @(negedge clk); cmp_valid = 4'b0010;
    @(negedge clk); cmp_valid = 4'b0000; req_valid = 1'b1; req_cls = 2'd1; #5;
    check(req_grant, 1'b1, "read released after completion");
    @(negedge clk); req_valid = 1'b0;
    repeat (30) step(0, 4'b0000, 4'b0000, 60, 0);
    phase("R2",  4'b0000, 4'b0000,  0, 35, 0, 300);
    phase("R3",  4'b0000, 4'b0111, 40, 35, 0, 300);
    phase("R3",  4'b1100, 4'b0000, 40, 35, 0, 300);
    phase("R4",  4'b0011, 4'b0011, 15, 35, 0, 1500);
    phase("R5",  4'b0010, 4'b0010, 15, 35, 0, 1500);
    phase("R6",  4'b0001, 4'b0001, 15, 35, 0, 1500);
    phase("R7",  4'b0010, 4'b0011, 15, 35, 0, 1500);
    phase("R8",  4'b0011, 4'b0001, 15, 35, 0, 1500);
    phase("R9",  4'b0010, 4'b0001, 20, 25, 0, 2000);
    phase("R9",  4'b1100, 4'b0011, 20, 25, 0, 2000);
    phase("R10", 4'b0000, 4'b0000,  0, 35, 1, 1500);
    phase("R11", 4'b0000, 4'b0000,  0, 35, 2, 1500);
    phase("R11", 4'b0000, 4'b0000,  0, 35, 3, 1500);
    phase("R12", 4'b0011, 4'b0011, 60, 10, 1, 2000);
    phase("R12", 4'b1111, 4'b1111, 70, 15, 3, 2000);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule